// File: doc/BRIEF.md
# Superpage Translation Buffer with Not-Most-Recently-Used Refill

This block is a small fully associative address translation buffer for a processor core. Every slot holds one mapping from a virtual page number to a physical frame number, tagged with an address space number. A slot can cover a naturally aligned block of 1, 8, 64 or 512 base pages, chosen by a 2-bit size code. The low page-number bits that fall inside the block are left out of the tag compare and are copied from the virtual address into the physical address. A slot marked global matches under any address space number, so mappings shared by all processes need only one slot.

A lookup presents a virtual address and the current address space number. The hit flag, the slot index and the physical address come back on the next clock. Refill is done by privileged firmware through a write port that carries a full mapping. The hardware picks the slot to overwrite. It uses the lowest empty slot when one exists. Otherwise it uses the slot after the most recently used one, so the most recently used mapping is never evicted. A single-cycle flush input empties the whole buffer.

Top module: `sptlb_top`

## Requirements
- R1: A lookup request is answered exactly one clock later: `rsp_valid` is high in the cycle after `lk_req` was high and low in the cycle after it was low. All response outputs and `victim_idx` read 0 after reset.
- R2: A slot matches when it is valid, its global bit is set or its stored number equals `lk_asn`, and its page number equals the looked-up page number (`lk_va[31:13]`) on every bit above the size-masked low bits. When several slots match, the lowest index wins. On a hit, `rsp_pa` is the translated frame followed by `lk_va[12:0]`. On a miss, `rsp_hit`, `rsp_idx` and `rsp_pa` are all 0.
- R3: The size code g (0..3) makes a slot cover 8^g pages: the low 3·g page-number bits are ignored in the compare and are passed from the virtual page number into the same bits of the physical frame.
- R4: A slot written with `fill_glob` = 1 hits for every value of `lk_asn`. A slot with `fill_glob` = 0 misses when the number differs.
- R5: When a slot is written, the low 3·g bits of `fill_pfn` are stored as zero, so a misaligned frame reads back aligned.
- R6: `victim_idx` shows the slot the next fill will write: the lowest invalid slot if any slot is invalid, otherwise (most-recently-used index + 1) modulo the slot count. When all slots are valid, it never equals the most recently used slot.
- R7: The most-recently-used index takes the written slot on every fill. Otherwise it takes the hit slot on every lookup hit. A fill has priority over a hit in the same cycle.
- R8: `flush_all` clears every valid bit in one cycle and takes priority over a fill in the same cycle, which is dropped. Afterwards `victim_idx` is 0.
- R9: A lookup in the same cycle as a fill or a flush sees the contents from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_all | input | 1 | Invalidate every slot |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address to translate |
| lk_asn | input | 8 | Current address space number |
| fill_req | input | 1 | Write a mapping into slot `victim_idx` |
| fill_vpn | input | 19 | Virtual page number of the mapping |
| fill_pfn | input | 19 | Physical frame number of the mapping |
| fill_asn | input | 8 | Address space number of the mapping |
| fill_gran | input | 2 | Size code g, block of 8^g pages |
| fill_glob | input | 1 | Match under every address space number |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_idx | output | 3 | Index of the hit slot |
| rsp_pa | output | 32 | Translated physical address |
| victim_idx | output | 3 | Slot the next fill will write |

## Verification
Lookup results are due one edge after the request. Fills, flushes and most-recently-used updates take effect at that same edge, so the `victim_idx` value that reflects a cycle's stimulus is readable in the following low clock phase. The bench drives every input on the falling edge. It computes the expected response from a reference model in the state it had before the rising edge, then advances the model. At the next falling edge it compares `rsp_*` against that expectation and `victim_idx` against the updated model. A lookup issued in the same cycle as a fill or flush is therefore held to the old contents.

// File: rtl/sptlb_pkg.sv
// Package: shared constants and helpers for the superpage translation buffer.
// Assumes the size code is 2 bits wide and each step multiplies the block by 8.
package sptlb_pkg;

    localparam int GRAN_W    = 2;
    localparam int GRAN_STEP = 3;
    localparam int GRAN_SPAN = GRAN_STEP * ((1 << GRAN_W) - 1);

    typedef logic [GRAN_W-1:0] gran_t;

    // Low page-number bits that a given size code leaves out of the compare.
    function automatic logic [GRAN_SPAN-1:0] gran_low_mask(input gran_t g);
        logic [GRAN_SPAN-1:0] m;
        m = '0;
        for (int b = 0; b < GRAN_SPAN; b++) begin
            if (b < GRAN_STEP * int'(g)) m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/sptlb_entry.sv
// Module: one translation slot with its stored mapping and its match logic.
// Assumes VPN_W and PFN_W are at least GRAN_SPAN bits. A clear has priority
// over a write. The stored frame is aligned to its block size on write.
module sptlb_entry
    import sptlb_pkg::*;
#(
    parameter int VPN_W = 19,
    parameter int PFN_W = 19,
    parameter int ASN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PFN_W-1:0] wr_pfn,
    input  logic [ASN_W-1:0] wr_asn,
    input  gran_t            wr_gran,
    input  logic             wr_glob,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [ASN_W-1:0] lk_asn,
    output logic             valid,
    output logic             match,
    output logic [PFN_W-1:0] xlat_pfn
);

    localparam int VPN_HI = VPN_W - GRAN_SPAN;
    localparam int PFN_HI = PFN_W - GRAN_SPAN;

    logic [VPN_W-1:0]     s_vpn;
    logic [PFN_W-1:0]     s_pfn;
    logic [ASN_W-1:0]     s_asn;
    gran_t                s_gran;
    logic                 s_glob;
    logic [GRAN_SPAN-1:0] wr_low;
    logic [GRAN_SPAN-1:0] s_low;
    logic [VPN_W-1:0]     cmp_keep;
    logic                 asn_ok;
    logic                 tag_ok;

    assign wr_low = gran_low_mask(wr_gran);
    assign s_low  = gran_low_mask(s_gran);

    // Purpose: hold the slot's mapping, clearing the valid bit on flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid  <= 1'b0;
            s_vpn  <= '0;
            s_pfn  <= '0;
            s_asn  <= '0;
            s_gran <= '0;
            s_glob <= 1'b0;
        end else if (clr) begin
            valid  <= 1'b0;
        end else if (wr_en) begin
            valid  <= 1'b1;
            s_vpn  <= wr_vpn;
            s_pfn  <= {wr_pfn[PFN_W-1:GRAN_SPAN], wr_pfn[GRAN_SPAN-1:0] & ~wr_low};
            s_asn  <= wr_asn;
            s_gran <= wr_gran;
            s_glob <= wr_glob;
        end
    end

    // Purpose: compare the looked-up page and address space against the slot.
    always_comb begin
        cmp_keep = {{VPN_HI{1'b1}}, ~s_low};
        asn_ok   = s_glob || (s_asn == lk_asn);
        tag_ok   = ((s_vpn ^ lk_vpn) & cmp_keep) == '0;
        match    = valid && asn_ok && tag_ok;
    end

    // Purpose: merge the in-block page bits into the aligned frame.
    always_comb begin
        xlat_pfn = {s_pfn[PFN_W-1:GRAN_SPAN],
                    s_pfn[GRAN_SPAN-1:0] | (lk_vpn[GRAN_SPAN-1:0] & s_low)};
    end

    logic [PFN_HI-1:0] unused_hi;
    assign unused_hi = '0;

endmodule

// File: rtl/sptlb_hit_sel.sv
// Module: picks the lowest matching slot and routes out its translated frame.
// Assumes match_vec and pfn_flat are indexed by slot. Gives zeros on no match.
module sptlb_hit_sel #(
    parameter int N_SLOTS = 8,
    parameter int PFN_W   = 19,
    localparam int IDX_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic [N_SLOTS-1:0]       match_vec,
    input  logic [N_SLOTS*PFN_W-1:0] pfn_flat,
    output logic                     any_hit,
    output logic [IDX_W-1:0]         hit_idx,
    output logic [PFN_W-1:0]         hit_pfn
);

    // Purpose: priority select, scanning downward so the lowest index wins.
    always_comb begin
        any_hit = 1'b0;
        hit_idx = '0;
        hit_pfn = '0;
        for (int i = N_SLOTS - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                any_hit = 1'b1;
                hit_idx = IDX_W'(i);
                hit_pfn = pfn_flat[i*PFN_W +: PFN_W];
            end
        end
    end

endmodule

// File: rtl/sptlb_nmru.sv
// Module: tracks the most recently used slot and names the refill victim.
// Assumes a fill and a hit never change the tracker in the same cycle: the
// fill wins. The victim is the lowest empty slot, or the slot after the last used.
module sptlb_nmru #(
    parameter int N_SLOTS = 8,
    localparam int IDX_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SLOTS-1:0] valid_vec,
    input  logic               fill_upd,
    input  logic [IDX_W-1:0]   fill_idx,
    input  logic               hit_upd,
    input  logic [IDX_W-1:0]   hit_idx,
    output logic [IDX_W-1:0]   mru_idx,
    output logic [IDX_W-1:0]   victim
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_SLOTS - 1);

    logic             has_free;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] after_mru;

    // Purpose: record the last slot touched by a fill or a lookup hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mru_idx <= '0;
        end else if (fill_upd) begin
            mru_idx <= fill_idx;
        end else if (hit_upd) begin
            mru_idx <= hit_idx;
        end
    end

    // Purpose: find the lowest empty slot.
    always_comb begin
        has_free = 1'b0;
        free_idx = '0;
        for (int i = N_SLOTS - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                has_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    // Purpose: choose the victim, skipping the most recently used slot.
    always_comb begin
        after_mru = (mru_idx == LAST) ? '0 : mru_idx + 1'b1;
        victim    = has_free ? free_idx : after_mru;
    end

endmodule

// File: rtl/sptlb_top.sv
// Module: fully associative superpage translation buffer, top level.
// Assumes firmware writes through the fill port into the slot named by
// victim_idx. Lookups are registered and answered one cycle later.
module sptlb_top
    import sptlb_pkg::*;
#(
    parameter int N_SLOTS    = 8,
    parameter int VA_W       = 32,
    parameter int PA_W       = 32,
    parameter int PAGE_SHIFT = 13,
    parameter int ASN_W      = 8,
    localparam int VPN_W     = VA_W - PAGE_SHIFT,
    localparam int PFN_W     = PA_W - PAGE_SHIFT,
    localparam int IDX_W     = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_all,
    input  logic             lk_req,
    input  logic [VA_W-1:0]  lk_va,
    input  logic [ASN_W-1:0] lk_asn,
    input  logic             fill_req,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic [ASN_W-1:0] fill_asn,
    input  logic [1:0]       fill_gran,
    input  logic             fill_glob,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [IDX_W-1:0] rsp_idx,
    output logic [PA_W-1:0]  rsp_pa,
    output logic [IDX_W-1:0] victim_idx
);

    logic [VPN_W-1:0]         lk_vpn;
    logic [N_SLOTS-1:0]       valid_vec;
    logic [N_SLOTS-1:0]       match_vec;
    logic [N_SLOTS*PFN_W-1:0] pfn_flat;
    logic                     any_hit;
    logic [IDX_W-1:0]         hit_idx;
    logic [PFN_W-1:0]         hit_pfn;
    logic [IDX_W-1:0]         mru_idx;
    logic                     fill_go;

    assign lk_vpn  = lk_va[VA_W-1:PAGE_SHIFT];
    assign fill_go = fill_req && !flush_all;

    // One slot per index, written only when it is the current victim.
    for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
        logic [PFN_W-1:0] slot_pfn;
        sptlb_entry #(
            .VPN_W (VPN_W),
            .PFN_W (PFN_W),
            .ASN_W (ASN_W)
        ) u_entry (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (flush_all),
            .wr_en    (fill_go && (victim_idx == IDX_W'(i))),
            .wr_vpn   (fill_vpn),
            .wr_pfn   (fill_pfn),
            .wr_asn   (fill_asn),
            .wr_gran  (gran_t'(fill_gran)),
            .wr_glob  (fill_glob),
            .lk_vpn   (lk_vpn),
            .lk_asn   (lk_asn),
            .valid    (valid_vec[i]),
            .match    (match_vec[i]),
            .xlat_pfn (slot_pfn)
        );
        assign pfn_flat[i*PFN_W +: PFN_W] = slot_pfn;
    end

    sptlb_hit_sel #(
        .N_SLOTS (N_SLOTS),
        .PFN_W   (PFN_W)
    ) u_hit_sel (
        .match_vec (match_vec),
        .pfn_flat  (pfn_flat),
        .any_hit   (any_hit),
        .hit_idx   (hit_idx),
        .hit_pfn   (hit_pfn)
    );

    sptlb_nmru #(
        .N_SLOTS (N_SLOTS)
    ) u_nmru (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_vec (valid_vec),
        .fill_upd  (fill_go),
        .fill_idx  (victim_idx),
        .hit_upd   (lk_req && any_hit),
        .hit_idx   (hit_idx),
        .mru_idx   (mru_idx),
        .victim    (victim_idx)
    );

    // Purpose: register the lookup result, zeroing it on a miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_idx   <= '0;
            rsp_pa    <= '0;
        end else begin
            rsp_valid <= lk_req;
            rsp_hit   <= lk_req && any_hit;
            rsp_idx   <= (lk_req && any_hit) ? hit_idx : '0;
            rsp_pa    <= (lk_req && any_hit) ? {hit_pfn, lk_va[PAGE_SHIFT-1:0]} : '0;
        end
    end

endmodule

// File: rtl/sptlb_chk.sv
// Module: protocol and replacement checks for sptlb_top, attached by bind.
// Assumes it observes the top's ports plus its slot valid bits and tracker.
module sptlb_chk #(
    parameter int N_SLOTS    = 8,
    parameter int VA_W       = 32,
    parameter int PA_W       = 32,
    parameter int PAGE_SHIFT = 13,
    localparam int IDX_W     = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flush_all,
    input logic               lk_req,
    input logic [VA_W-1:0]    lk_va,
    input logic               fill_req,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic [PA_W-1:0]    rsp_pa,
    input logic [IDX_W-1:0]   victim_idx,
    input logic [N_SLOTS-1:0] valid_vec,
    input logic [IDX_W-1:0]   mru_idx
);

    // R1
    rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rsp_valid == $past(lk_req)));

    // R2
    hit_needs_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);

    // R2
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> (rsp_pa[PAGE_SHIFT-1:0] ==
                    (rsp_hit ? $past(lk_va[PAGE_SHIFT-1:0]) : '0)));

    // R6
    nmru_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&valid_vec) |-> (victim_idx != mru_idx));

    // R6
    free_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(&valid_vec) |-> !valid_vec[victim_idx]);

    // R7
    fill_mru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !flush_all) |=> (mru_idx == $past(victim_idx)));

    // R8
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (valid_vec == '0 && victim_idx == '0));

endmodule

bind sptlb_top sptlb_chk #(
    .N_SLOTS    (N_SLOTS),
    .VA_W       (VA_W),
    .PA_W       (PA_W),
    .PAGE_SHIFT (PAGE_SHIFT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_all  (flush_all),
    .lk_req     (lk_req),
    .lk_va      (lk_va),
    .fill_req   (fill_req),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_pa     (rsp_pa),
    .victim_idx (victim_idx),
    .valid_vec  (valid_vec),
    .mru_idx    (mru_idx)
);

// File: tb/sptlb_top_tb.sv
// Bench: reference-model checking of sptlb_top with directed and random stimulus.
module sptlb_top_tb;

    localparam int N     = 8;
    localparam int PS    = 13;
    localparam int VPN_W = 19;
    localparam int PFN_W = 19;
    localparam int ASN_W = 8;
    localparam int IDX_W = 3;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             flush_all;
    logic             lk_req;
    logic [31:0]      lk_va;
    logic [ASN_W-1:0] lk_asn;
    logic             fill_req;
    logic [VPN_W-1:0] fill_vpn;
    logic [PFN_W-1:0] fill_pfn;
    logic [ASN_W-1:0] fill_asn;
    logic [1:0]       fill_gran;
    logic             fill_glob;
    logic             rsp_valid;
    logic             rsp_hit;
    logic [IDX_W-1:0] rsp_idx;
    logic [31:0]      rsp_pa;
    logic [IDX_W-1:0] victim_idx;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    sptlb_top u_dut (
        .clk(clk), .rst_n(rst_n), .flush_all(flush_all),
        .lk_req(lk_req), .lk_va(lk_va), .lk_asn(lk_asn),
        .fill_req(fill_req), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .fill_asn(fill_asn), .fill_gran(fill_gran), .fill_glob(fill_glob),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_idx(rsp_idx),
        .rsp_pa(rsp_pa), .victim_idx(victim_idx)
    );

    // Reference model state
    logic             m_v    [N];
    logic [VPN_W-1:0] m_vpn  [N];
    logic [PFN_W-1:0] m_pfn  [N];
    logic [ASN_W-1:0] m_asn  [N];
    logic [1:0]       m_gran [N];
    logic             m_glob [N];
    int               m_mru;

    function automatic logic [VPN_W-1:0] low_of(input logic [1:0] g);
        return VPN_W'((1 << (3 * int'(g))) - 1);
    endfunction

    function automatic int model_victim();
        for (int i = 0; i < N; i++) if (!m_v[i]) return i;
        return (m_mru + 1) % N;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        flush_all = 0; lk_req = 0; lk_va = '0; lk_asn = '0;
        fill_req = 0; fill_vpn = '0; fill_pfn = '0; fill_asn = '0;
        fill_gran = '0; fill_glob = 0;
    endtask

    // One clock: predict from pre-edge model, advance model, compare at negedge.
    task automatic step(input string req);
        logic        e_hit = 0;
        int          e_idx = 0;
        logic [31:0] e_pa  = '0;
        logic [VPN_W-1:0] lv;
        int vic;
        lv = lk_va[31:PS];
        for (int i = N - 1; i >= 0; i--) begin
            logic [VPN_W-1:0] lo;
            lo = low_of(m_gran[i]);
            if (m_v[i] && (m_glob[i] || m_asn[i] == lk_asn) &&
                (((m_vpn[i] ^ lv) & ~lo) == '0)) begin
                e_hit = 1; e_idx = i;
                e_pa  = {(m_pfn[i] & ~lo) | (lv & lo), lk_va[PS-1:0]};
            end
        end
        vic = model_victim();
        if (fill_req && !flush_all) begin
            m_v[vic] = 1; m_vpn[vic] = fill_vpn;
            m_pfn[vic] = fill_pfn & ~low_of(fill_gran);
            m_asn[vic] = fill_asn; m_gran[vic] = fill_gran;
            m_glob[vic] = fill_glob; m_mru = vic;
        end else if (lk_req && e_hit) begin
            m_mru = e_idx;
        end
        if (flush_all) for (int i = 0; i < N; i++) m_v[i] = 0;
        if (!lk_req) begin
            e_hit = 0; e_idx = 0; e_pa = '0;
        end
        begin
            logic was_req;
            was_req = lk_req;
            @(negedge clk);
            chk("R1", "rsp_valid", 32'(rsp_valid), 32'(was_req));
            if (was_req) begin
                chk(req, "rsp_hit", 32'(rsp_hit), 32'(e_hit));
                chk(req, "rsp_idx", 32'(rsp_idx), 32'(e_idx));
                chk(req, "rsp_pa", rsp_pa, e_pa);
            end
            chk(req, "victim_idx", 32'(victim_idx), 32'(model_victim()));
        end
        idle();
    endtask

    task automatic set_fill(input logic [VPN_W-1:0] v, input logic [PFN_W-1:0] p,
                            input logic [ASN_W-1:0] a, input logic [1:0] g,
                            input logic gl);
        fill_req = 1; fill_vpn = v; fill_pfn = p; fill_asn = a;
        fill_gran = g; fill_glob = gl;
    endtask

    task automatic set_look(input logic [VPN_W-1:0] v, input logic [PS-1:0] off,
                            input logic [ASN_W-1:0] a);
        lk_req = 1; lk_va = {v, off}; lk_asn = a;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_vpn[i] = '0; m_pfn[i] = '0;
            m_asn[i] = '0; m_gran[i] = '0; m_glob[i] = 0;
        end
        m_mru = 0;
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1", "reset rsp_valid", 32'(rsp_valid), 0);
        chk("R1", "reset rsp_pa", rsp_pa, 0);
        chk("R1", "reset victim_idx", 32'(victim_idx), 0);

        // R9: fill and lookup of the same page in one cycle sees old contents
        set_fill(19'h00100, 19'h02222, 8'd5, 2'd0, 0);
        set_look(19'h00100, 13'h0ABC, 8'd5);
        step("R9");
        chk("R9", "same-cycle miss", 32'(rsp_hit), 0);
        // R2: basic hit, exact page, offset carried
        set_look(19'h00100, 13'h1234, 8'd5);
        step("R2");
        chk("R2", "explicit pa", rsp_pa, {19'h02222, 13'h1234});
        // R2/R4: wrong address space number misses for a non-global slot
        set_look(19'h00100, 13'h0001, 8'd6);
        step("R4");
        chk("R4", "non-global asn miss", 32'(rsp_hit), 0);

        // R5/R3/R4: global 64-page block with misaligned frame
        set_fill(19'h00A40, 19'h0117F, 8'd1, 2'd2, 1);
        step("R5");
        set_look(19'h00A6B, 13'h0010, 8'd77);
        step("R3");
        chk("R5", "aligned frame merge", rsp_pa, {19'h0116B, 13'h0010});
        set_look(19'h00A80, 13'h0010, 8'd1);
        step("R3");
        chk("R3", "outside block miss", 32'(rsp_hit), 0);
        // R3: 512-page block covers the far end
        set_fill(19'h40000, 19'h10000, 8'd2, 2'd3, 0);
        step("R3");
        set_look(19'h401FF, 13'h1FFF, 8'd2);
        step("R3");
        chk("R3", "512-page top", rsp_pa, {19'h101FF, 13'h1FFF});
        // R3: 8-page block
        set_fill(19'h00208, 19'h03330, 8'd2, 2'd1, 0);
        step("R3");
        set_look(19'h0020F, 13'h0000, 8'd2);
        step("R3");

        // R6: fill the rest, victims go in order of empty slots
        for (int k = 0; k < 4; k++) begin
            set_fill(19'h01000 + 19'(k), 19'h05000 + 19'(k), 8'd3, 2'd0, 0);
            step("R6");
        end
        chk("R6", "full wrap victim", 32'(victim_idx), 0);
        // R7: hit slot 2 makes victim 3
        set_look(19'h40005, 13'h0, 8'd2);
        step("R7");
        chk("R7", "victim after hit", 32'(victim_idx), 3);
        // R7: fill and hit in one cycle, fill wins the tracker
        set_fill(19'h02000, 19'h06000, 8'd4, 2'd0, 0);
        set_look(19'h00100, 13'h0, 8'd5);
        step("R7");
        chk("R7", "fill beats hit", 32'(victim_idx), 4);
        // R2: overlapping slots, lowest index wins
        set_fill(19'h00100, 19'h07777, 8'd5, 2'd0, 0);
        step("R2");
        set_look(19'h00100, 13'h0, 8'd5);
        step("R2");
        chk("R2", "lowest index wins", 32'(rsp_idx), 0);

        // R8: flush with a fill in the same cycle drops the fill
        flush_all = 1;
        set_fill(19'h03000, 19'h01000, 8'd0, 2'd0, 1);
        set_look(19'h00100, 13'h0, 8'd5);
        step("R9");
        chk("R9", "lookup during flush hits", 32'(rsp_hit), 1);
        chk("R8", "victim after flush", 32'(victim_idx), 0);
        set_look(19'h03000, 13'h0, 8'd0);
        step("R8");
        chk("R8", "dropped fill misses", 32'(rsp_hit), 0);

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            if (($urandom % 100) < 15)
                set_fill(19'($urandom % 1024), 19'($urandom),
                         8'($urandom % 4), 2'($urandom), (($urandom % 4) == 0));
            if (($urandom % 100) < 70)
                set_look(19'($urandom % 1024), 13'($urandom), 8'($urandom % 4));
            if (($urandom % 200) == 0) flush_all = 1;
            step("R2");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule